// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter fed by a divided clock. It is used either to catch a stalled program or to raise a periodic interrupt. A free-running prescaler makes single-cycle ticks from one of two sources. The first source is the main clock, with taps from /2 up to /131072. The second is a slow sub-clock enable, with taps from /2 up to /256. Each tick advances the counter by one.

In watchdog mode, the counter wrapping from 0xFF to 0x00 produces a one-cycle request. That request goes to the reset sequencer or to the non-maskable interrupt input. Software prevents it by rewriting the counter in time. In interval mode, each wrap sets an overflow flag, and an interrupt request stays high while the flag is set. Software clears the flag in two steps: it reads the flag as 1, then writes 0 to it.

A two-register bus gives access to the block. Address 0 is the counter. Address 1 is the control/status byte, laid out as follows:
- bit 7: overflow flag
- bit 6: mode, 1 = watchdog
- bit 5: enable
- bit 4: source, 1 = sub-clock
- bit 3: action, 1 = NMI
- bits 2:0: divider code

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset the counter reads 0x00, the control byte reads 0x00, and rst_req, nmi_req and irq are low.
- R2: While the enable bit (control bit 5) is 0, the counter reads 0x00, writes to the counter are ignored, and the prescaler is held at zero.
- R3: With control bit 4 at 0, the counter advances once every 2, 64, 128, 512, 2048, 8192, 32768 or 131072 main clock cycles for divider codes 0 to 7. The prescaler restarts when the block is enabled.
- R4: With control bit 4 at 1, the counter advances once every 2^(code+1) cycles on which sub_tick_en is high.
- R5: A write to address 0 loads the counter. This write takes priority over a tick in the same cycle and suppresses that overflow.
- R6: In watchdog mode (bit 6 = 1), an overflow gives a one-cycle pulse in the following cycle. The pulse is on rst_req when bit 3 is 0 and on nmi_req when bit 3 is 1. The counter wraps to 0x00 and keeps counting.
- R7: Every overflow sets the flag (bit 7). irq is high whenever the flag is 1 and bit 6 is 0, and the counter keeps counting.
- R8: Writing 0 to bit 7 clears the flag only after a read of address 1 (bus_rd) that returned the flag as 1. That clear uses up the read. Writing 1 to bit 7 never changes the flag.
- R9: When an overflow and an allowed clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick_en | input | 1 | One-cycle enable marking each slow sub-clock period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used to arm the flag clear) |
| bus_addr | input | 1 | 0 = counter, 1 = control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| rst_req | output | 1 | Watchdog reset request pulse |
| nmi_req | output | 1 | Watchdog NMI request pulse |
| irq | output | 1 | Interval interrupt request |

## Verification
The counter is run from the main clock at four divider codes and from a sparse sub-clock enable at two codes. This separates the tap decoding of each source and shows that the prescaler restarts on enable. Overflows are caused in both modes and with both action settings, which tells the reset path from the NMI path and the flag-driven interrupt. A regular counter-rewrite pattern checks that a watchdog kept alive never fires.

Flag handling is tried in four cases:
- a clear with no prior read;
- a write of 1;
- a clear after a read;
- a clear timed onto the overflow cycle.

Together these separate the arm, consume and priority rules.

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
  parameter int MAIN_W = 17,
  parameter int SUB_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick_en,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_req,
  output logic       nmi_req,
  output logic       irq
);

  logic [7:0] cnt;
  logic       flag, armed, mode_wd, en, src_sub, act_nmi;
  logic [2:0] cks;
  logic [MAIN_W-1:0] pre_main, main_mask;
  logic [SUB_W-1:0]  pre_sub, sub_mask;
  int main_shift;

  always_comb begin
    case (cks)
      3'd0: main_shift = 1;
      3'd1: main_shift = 6;
      3'd2: main_shift = 7;
      3'd3: main_shift = 9;
      3'd4: main_shift = 11;
      3'd5: main_shift = 13;
      3'd6: main_shift = 15;
      default: main_shift = 17;
    endcase
  end

  assign main_mask = MAIN_W'((64'd1 << main_shift) - 64'd1);
  assign sub_mask  = SUB_W'((64'd1 << (int'(cks) + 1)) - 64'd1);

  logic tick, wr_cnt, wr_ctl, rd_ctl, ovf, clear_ok;

  assign tick = en && (src_sub ? (sub_tick_en && ((pre_sub & sub_mask) == sub_mask))
                               : ((pre_main & main_mask) == main_mask));
  assign wr_cnt   = bus_wr && !bus_addr;
  assign wr_ctl   = bus_wr && bus_addr;
  assign rd_ctl   = bus_rd && bus_addr;
  assign ovf      = tick && (cnt == 8'hFF) && !wr_cnt;
  assign clear_ok = wr_ctl && !bus_wdata[7] && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_main <= '0;
      pre_sub  <= '0;
    end else if (!en) begin
      pre_main <= '0;
      pre_sub  <= '0;
    end else begin
      pre_main <= pre_main + 1'b1;
      if (sub_tick_en) pre_sub <= pre_sub + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata;
    else if (tick)   cnt <= cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed   <= 1'b0;
      mode_wd <= 1'b0;
      en      <= 1'b0;
      src_sub <= 1'b0;
      act_nmi <= 1'b0;
      cks     <= '0;
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      if (ovf)           flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;
      if (clear_ok)                armed <= 1'b0;
      else if (rd_ctl && flag)     armed <= 1'b1;
      if (wr_ctl) begin
        mode_wd <= bus_wdata[6];
        en      <= bus_wdata[5];
        src_sub <= bus_wdata[4];
        act_nmi <= bus_wdata[3];
        cks     <= bus_wdata[2:0];
      end
      rst_req <= ovf && mode_wd && !act_nmi;
      nmi_req <= ovf && mode_wd && act_nmi;
    end
  end

  assign irq       = flag && !mode_wd;
  assign bus_rdata = bus_addr ? {flag, mode_wd, en, src_sub, act_nmi, cks} : cnt;

  a_r2_disabled_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == 8'h00));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |=> !(rst_req || nmi_req));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req));
  a_r6_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |-> ($past(cnt) == 8'hFF));
  a_r7_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == 8'hFF));
  a_r8_no_unarmed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);

endmodule

// File: tb/test_wdt_interval_timer.sv
`timescale 1ns/100ps
module test_wdt_interval_timer;
  logic clk = 0, rst_n = 0, sub_tick_en = 0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic rst_req, nmi_req, irq;

  wdt_interval_timer i_wdt_interval_timer (
    .clk(clk), .rst_n(rst_n), .sub_tick_en(sub_tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .nmi_req(nmi_req), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int rst_seen = 0, nmi_seen = 0;
  string phase = "R1";

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int mdiv[8] = '{2, 64, 128, 512, 2048, 8192, 32768, 131072};
  int m_cnt, m_pm, m_ps, m_cks;
  bit m_flag, m_armed, m_wd, m_en, m_src, m_nmi, m_rst_q, m_nmi_q;

  function automatic bit main_tick_next();
    return m_en && !m_src && ((m_pm % mdiv[m_cks]) == mdiv[m_cks] - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pm = 0; m_ps = 0; m_cks = 0;
      m_flag = 0; m_armed = 0; m_wd = 0; m_en = 0; m_src = 0; m_nmi = 0;
      m_rst_q = 0; m_nmi_q = 0;
    end else begin
      bit tk, wrc, wrt, rdt, ov, clr;
      int sd;
      sd  = 2 << m_cks;
      tk  = m_en && (m_src ? (sub_tick_en && (m_ps % sd) == sd - 1)
                           : ((m_pm % mdiv[m_cks]) == mdiv[m_cks] - 1));
      wrc = bus_wr && !bus_addr;
      wrt = bus_wr && bus_addr;
      rdt = bus_rd && bus_addr;
      ov  = tk && m_cnt == 255 && !wrc;
      clr = wrt && !bus_wdata[7] && m_armed;
      m_rst_q = ov && m_wd && !m_nmi;
      m_nmi_q = ov && m_wd && m_nmi;
      if (!m_en) m_cnt = 0;
      else if (wrc) m_cnt = bus_wdata;
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (clr) m_armed = 0; else if (rdt && m_flag) m_armed = 1;
      if (ov) m_flag = 1; else if (clr) m_flag = 0;
      if (m_en) begin m_pm++; if (sub_tick_en) m_ps++; end
      else begin m_pm = 0; m_ps = 0; end
      if (wrt) begin
        m_wd = bus_wdata[6]; m_en = bus_wdata[5]; m_src = bus_wdata[4];
        m_nmi = bus_wdata[3]; m_cks = bus_wdata[2:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_rd;
      exp_rd = bus_addr ? {m_flag, m_wd, m_en, m_src, m_nmi, 3'(m_cks)} : 8'(m_cnt);
      check(phase, bus_rdata, exp_rd);
      check("R6", {rst_req, nmi_req}, {m_rst_q, m_nmi_q});
      check("R7", irq, m_flag && !m_wd);
      if (rst_req) rst_seen++;
      if (nmi_req) nmi_seen++;
    end
  end

  int sub_div = 0;
  always @(negedge clk) begin
    sub_div <= (sub_div == 6) ? 0 : sub_div + 1;
    sub_tick_en <= (sub_div == 6);
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(); endtask
  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
  endtask
  task automatic rd(input logic a);
    bus_rd = 1; bus_addr = a; cyc(); bus_rd = 0;
  endtask
  task automatic peek(input logic a, output logic [7:0] v);
    bus_addr = a; #0.5; v = bus_rdata;
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r0, n0;
    idle(4); rst_n = 1; idle(3);
    peek(0, v); check("R1", v, 8'h00);
    peek(1, v); check("R1", v, 8'h00);
    check("R1", {rst_req, nmi_req, irq}, 0);

    phase = "R2";
    wr(0, 8'h55); idle(2);
    peek(0, v); check("R2", v, 8'h00);

    phase = "R3";
    wr(1, 8'h20); idle(100);
    wr(1, 8'h21); idle(300);
    wr(1, 8'h23); idle(2000);
    wr(1, 8'h24); idle(5000);

    phase = "R5";
    wr(1, 8'h20); wr(0, 8'hFD); idle(12);
    phase = "R7";
    idle(20);
    check("R7", irq, 1);
    peek(1, v); check("R7", v[7], 1);

    phase = "R8";
    wr(1, 8'h20); idle(2);
    peek(1, v); check("R8", v[7], 1);
    rd(1); wr(1, 8'hA0); idle(2);
    peek(1, v); check("R8", v[7], 1);
    wr(1, 8'h20); idle(2);
    peek(1, v); check("R8", v[7], 0);
    check("R8", irq, 0);

    phase = "R9";
    wr(0, 8'hFC); idle(12);
    rd(1); wr(0, 8'hFE);
    while (!(m_cnt == 255 && main_tick_next())) cyc();
    wr(1, 8'h20); idle(2);
    peek(1, v); check("R9", v[7], 1);

    phase = "R6";
    r0 = rst_seen; n0 = nmi_seen;
    wr(1, 8'h60); wr(0, 8'hF0); idle(60);
    check("R6", rst_seen - r0, 1); check("R6", nmi_seen - n0, 0);
    wr(1, 8'h68); wr(0, 8'hF0); idle(60);
    check("R6", rst_seen - r0, 1); check("R6", nmi_seen - n0, 1);
    wr(1, 8'h60); wr(0, 8'h00);
    for (int k = 0; k < 10; k++) begin idle(200); wr(0, 8'h00); end
    check("R5", rst_seen - r0, 1);

    phase = "R4";
    wr(1, 8'h30); bus_addr = 0; idle(4000);
    wr(1, 8'h32); bus_addr = 0; idle(3000);

    phase = "R2";
    wr(1, 8'h00); idle(3);
    peek(0, v); check("R2", v, 8'h00);
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule